// File: doc/BRIEF.md
# Descriptor-Chain DMA Sequencer

This block runs a chain of buffer descriptors held in system memory and turns each one into a command for a serial flash shift engine. Software programs a base address and writes the control register with both enable and start set. The sequencer then fetches each descriptor's control word, buffer address and next pointer over a word-wide memory port. It hands one command to the shift engine, giving length, direction, lane count, DDR, bit order, device select and chip-select release. After that it moves the payload in 32-bit words between the buffer and the engine's transmit or receive stream.

When a descriptor's data has moved, the sequencer writes its control word back with the ownership bit cleared. It can then raise a per-descriptor event and a per-packet event, and it either follows the next pointer or stops. Three things end the walk: a descriptor it does not own, a descriptor that marks the end of the list, or a null next pointer. A malformed descriptor raises an error event and halts the walk. Writing the control register with enable clear aborts the walk at once.

Top module: `bd_chain_dma`

## Requirements
- R1: After reset `busy`, `mem_req`, `cmd_valid`, `tx_valid` and all three event outputs are low.
- R2: A control write with enable (bit 0) and start (bit 2) both set starts the walk, and the first memory read goes to `base_addr`. A start written without enable does nothing.
- R3: Each issued command carries fields decoded from the control word (word 0 of the descriptor): length = bits [8:0], receive = bit 20, DDR = bit 21, LSB-first = bit 25, device = bits [29:28], CS release = bit 30. Lanes are 2 when bit 23 is set, 1 when only bit 22 is set, and 0 otherwise. The command holds stable until accepted.
- R4: For a transmit descriptor, ceil(length/4) words are read from consecutive addresses starting at the buffer address (word 2). They are presented on `tx_data` in order.
- R5: For a receive descriptor, ceil(length/4) words taken from the receive stream are written to consecutive addresses starting at the buffer address. No word beyond that range is written.
- R6: After its data has moved, a descriptor's control word is written back to its own address with bit 31 cleared.
- R7: On completion of a descriptor, `evt_bd_done` pulses for one cycle if bit 16 is set. `evt_pkt_done` pulses if bits 18 and 17 are both set.
- R8: The walk continues at the next pointer (word 3). It stops after a descriptor with bit 19 set, or after one whose next pointer is zero.
- R9: A fetched control word with bit 31 clear stops the walk with no command, no event and no write. If poll enable (bit 1) was set at start, the word is fetched again until bit 31 is found set.
- R10: A length of 0, a length above 256, or bits 22 and 23 both set makes `evt_err` pulse once. No command is issued, the descriptor is not written back, and the engine goes idle.
- R11: A control write with enable clear returns the engine to idle in the next cycle. Any memory request, command or transmit word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | {start, poll enable, enable} |
| base_addr | input | AW | Address of the first descriptor |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command offered to shift engine |
| cmd_ready | input | 1 | Shift engine accepts command |
| cmd_len | output | 9 | Byte count |
| cmd_rx | output | 1 | Receive direction |
| cmd_lanes | output | 2 | 0 single, 1 dual, 2 quad |
| cmd_ddr | output | 1 | Double data rate |
| cmd_lsb | output | 1 | LSB first |
| cmd_dev | output | 2 | Device select |
| cmd_cs_release | output | 1 | Release chip select after this command |
| tx_valid | output | 1 | Transmit word valid |
| tx_ready | input | 1 | Engine takes transmit word |
| tx_data | output | 32 | Transmit word |
| rx_valid | input | 1 | Receive word valid |
| rx_ready | output | 1 | Sequencer takes receive word |
| rx_data | input | 32 | Receive word |
| evt_bd_done | output | 1 | Descriptor done pulse |
| evt_pkt_done | output | 1 | Packet done pulse |
| evt_err | output | 1 | Malformed descriptor pulse |

## Verification
The results fall due at different times. The first descriptor read appears the cycle after the start write. The error pulse comes two cycles after the control word is acknowledged, once it has been registered and checked. The completion pulses come the cycle after the write-back acknowledge, the same edge at which `busy` falls on the final descriptor. Events and stream handshakes are logged by negative-edge monitors, so each pulse and each transfer is counted exactly once whatever its cycle. Memory contents, logs and counters are checked only after `busy` is seen low. The abort and poll cases sample `busy` and the request lines at fixed negative edges after the control write.

// File: rtl/bdseq_pkg.sv
package bdseq_pkg;
  localparam int unsigned OWN_B   = 31;
  localparam int unsigned CSREL_B = 30;
  localparam int unsigned DEV_LO  = 28;
  localparam int unsigned LSB_B   = 25;
  localparam int unsigned QUAD_B  = 23;
  localparam int unsigned DUAL_B  = 22;
  localparam int unsigned DDR_B   = 21;
  localparam int unsigned RX_B    = 20;
  localparam int unsigned EOL_B   = 19;
  localparam int unsigned LIF_B   = 18;
  localparam int unsigned IPKT_B  = 17;
  localparam int unsigned IBD_B   = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_FCTL, S_CHK, S_FBUF, S_FNXT, S_CMD,
    S_TRD, S_TSND, S_RWT, S_RWR, S_WB
  } seq_st_t;
endpackage

// File: rtl/bdseq_decode.sv
module bdseq_decode
  import bdseq_pkg::*;
#(
  parameter int MAX_LEN = 256,
  parameter int LW      = 9
) (
  input  logic [31:0]   word,
  output logic [LW-1:0] len,
  output logic          owned,
  output logic          bad,
  output logic          rx,
  output logic          ddr,
  output logic          lsb,
  output logic [1:0]    lanes,
  output logic [1:0]    dev,
  output logic          cs_rel,
  output logic          eol,
  output logic          lif,
  output logic          irq_pkt,
  output logic          irq_bd
);
  always_comb begin
    len     = word[LW-1:0];
    owned   = word[OWN_B];
    rx      = word[RX_B];
    ddr     = word[DDR_B];
    lsb     = word[LSB_B];
    dev     = word[DEV_LO +: 2];
    cs_rel  = word[CSREL_B];
    eol     = word[EOL_B];
    lif     = word[LIF_B];
    irq_pkt = word[IPKT_B];
    irq_bd  = word[IBD_B];
    if (word[QUAD_B])      lanes = 2'd2;
    else if (word[DUAL_B]) lanes = 2'd1;
    else                   lanes = 2'd0;
    bad = (len == '0) || (32'(len) > MAX_LEN) || (word[QUAD_B] && word[DUAL_B]);
  end
endmodule

// File: rtl/bdseq_beat_ctr.sv
module bdseq_beat_ctr #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] total,
  output logic [CW-1:0] idx,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst || load) idx <= '0;
    else if (step)   idx <= idx + 1'b1;
  end

  assign last = (idx == CW'(total - 1'b1));

  // R4
  beat_range_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load && total != '0) |-> (idx < total));
endmodule

// File: rtl/bd_chain_dma.sv
module bd_chain_dma
  import bdseq_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_LEN = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [2:0]    ctrl_wdata,
  input  logic [AW-1:0] base_addr,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [8:0]    cmd_len,
  output logic          cmd_rx,
  output logic [1:0]    cmd_lanes,
  output logic          cmd_ddr,
  output logic          cmd_lsb,
  output logic [1:0]    cmd_dev,
  output logic          cmd_cs_release,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [31:0]   tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [31:0]   rx_data,
  output logic          evt_bd_done,
  output logic          evt_pkt_done,
  output logic          evt_err
);
  localparam int LW = 9;
  localparam int CW = $clog2(MAX_LEN / 4 + 1);

  seq_st_t       st;
  logic [AW-1:0] cur, nxt, bufp;
  logic [31:0]   ctl, xq;
  logic          poll_q;
  logic          abort, kick;

  logic [LW-1:0] d_len;
  logic          d_own, d_bad, d_rx, d_ddr, d_lsb, d_csr, d_eol, d_lif, d_ipkt, d_ibd;
  logic [1:0]    d_lanes, d_dev;
  logic [CW-1:0] words, idx;
  logic          beat_last, beat_load, beat_step;

  assign abort = ctrl_wr && !ctrl_wdata[0];
  assign kick  = ctrl_wr && ctrl_wdata[0] && ctrl_wdata[2];

  bdseq_decode #(.MAX_LEN(MAX_LEN), .LW(LW)) dec_i (
    .word(ctl), .len(d_len), .owned(d_own), .bad(d_bad), .rx(d_rx),
    .ddr(d_ddr), .lsb(d_lsb), .lanes(d_lanes), .dev(d_dev), .cs_rel(d_csr),
    .eol(d_eol), .lif(d_lif), .irq_pkt(d_ipkt), .irq_bd(d_ibd)
  );

  assign words     = CW'((10'(d_len) + 10'd3) >> 2);
  assign beat_load = (st == S_CMD) && cmd_ready;
  assign beat_step = ((st == S_TSND) && tx_ready) || ((st == S_RWR) && mem_ack);

  bdseq_beat_ctr #(.CW(CW)) beat_i (
    .clk(clk), .rst(rst), .load(beat_load), .step(beat_step),
    .total(words), .idx(idx), .last(beat_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      cur          <= '0;
      nxt          <= '0;
      bufp         <= '0;
      ctl          <= '0;
      xq           <= '0;
      poll_q       <= 1'b0;
      evt_bd_done  <= 1'b0;
      evt_pkt_done <= 1'b0;
      evt_err      <= 1'b0;
    end else begin
      evt_bd_done  <= 1'b0;
      evt_pkt_done <= 1'b0;
      evt_err      <= 1'b0;
      if (abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (kick) begin
            cur    <= base_addr;
            poll_q <= ctrl_wdata[1];
            st     <= S_FCTL;
          end
          S_FCTL: if (mem_ack) begin
            ctl <= mem_rdata;
            st  <= S_CHK;
          end
          S_CHK: begin
            if (!d_own)     st <= poll_q ? S_FCTL : S_IDLE;
            else if (d_bad) begin
              evt_err <= 1'b1;
              st      <= S_IDLE;
            end else        st <= S_FBUF;
          end
          S_FBUF: if (mem_ack) begin
            bufp <= mem_rdata[AW-1:0];
            st   <= S_FNXT;
          end
          S_FNXT: if (mem_ack) begin
            nxt <= mem_rdata[AW-1:0];
            st  <= S_CMD;
          end
          S_CMD: if (cmd_ready) st <= d_rx ? S_RWT : S_TRD;
          S_TRD: if (mem_ack) begin
            xq <= mem_rdata;
            st <= S_TSND;
          end
          S_TSND: if (tx_ready) st <= beat_last ? S_WB : S_TRD;
          S_RWT: if (rx_valid) begin
            xq <= rx_data;
            st <= S_RWR;
          end
          S_RWR: if (mem_ack) st <= beat_last ? S_WB : S_RWT;
          S_WB: if (mem_ack) begin
            evt_bd_done  <= d_ibd;
            evt_pkt_done <= d_ipkt && d_lif;
            if (d_eol || nxt == '0) st <= S_IDLE;
            else begin
              cur <= nxt;
              st  <= S_FCTL;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = xq;
    case (st)
      S_FCTL: mem_req = 1'b1;
      S_FBUF: begin mem_req = 1'b1; mem_addr = cur + AW'(8);  end
      S_FNXT: begin mem_req = 1'b1; mem_addr = cur + AW'(12); end
      S_TRD:  begin mem_req = 1'b1; mem_addr = bufp + AW'({idx, 2'b00}); end
      S_RWR:  begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = bufp + AW'({idx, 2'b00});
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = ctl & ~(32'd1 << OWN_B);
      end
      default: ;
    endcase
  end

  assign busy           = (st != S_IDLE);
  assign cmd_valid      = (st == S_CMD);
  assign cmd_len        = d_len;
  assign cmd_rx         = d_rx;
  assign cmd_lanes      = d_lanes;
  assign cmd_ddr        = d_ddr;
  assign cmd_lsb        = d_lsb;
  assign cmd_dev        = d_dev;
  assign cmd_cs_release = d_csr;
  assign tx_valid       = (st == S_TSND);
  assign tx_data        = xq;
  assign rx_ready       = (st == S_RWT);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !cmd_valid && !tx_valid));

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && !abort) |=> (cmd_valid && $stable(cmd_len) && $stable(cmd_lanes)));

  // R10
  cmd_legal_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_len != '0 && 32'(cmd_len) <= MAX_LEN && cmd_lanes != 2'd3));

  // R10
  evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    evt_err |-> (!evt_bd_done && !evt_pkt_done));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);
endmodule

// File: tb/bd_chain_dma_tb_top.sv
`timescale 1ns/1ps
module bd_chain_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ctrl_wr = 1'b0;
  logic [2:0]  ctrl_wdata = '0;
  logic [31:0] base_addr = '0;
  logic        busy, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        cmd_valid, cmd_rx, cmd_ddr, cmd_lsb, cmd_cs_release;
  logic [8:0]  cmd_len;
  logic [1:0]  cmd_lanes, cmd_dev;
  logic        cmd_ready = 1'b1;
  logic        tx_valid, tx_ready, rx_ready, rx_valid;
  logic [31:0] tx_data, rx_data;
  logic        evt_bd_done, evt_pkt_done, evt_err;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  bd_chain_dma dut_i (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .base_addr(base_addr), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_len(cmd_len), .cmd_rx(cmd_rx), .cmd_lanes(cmd_lanes), .cmd_ddr(cmd_ddr),
    .cmd_lsb(cmd_lsb), .cmd_dev(cmd_dev), .cmd_cs_release(cmd_cs_release),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .evt_bd_done(evt_bd_done), .evt_pkt_done(evt_pkt_done), .evt_err(evt_err)
  );

  // memory model: one-cycle acknowledge
  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (!rst && mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  // receive stream source
  assign rx_valid = 1'b1;
  logic [31:0] rx_seq;
  always @(posedge clk) if (rx_valid && rx_ready) rx_seq <= rx_seq + 1;
  assign rx_data = rx_seq;

  // logging monitors
  logic [16:0] cmd_log [0:15];
  logic [31:0] tx_log  [0:127];
  int cmd_n, tx_n, bd_n, pkt_n, err_n;
  logic tx_rdy_q = 1'b1;
  assign tx_ready = tx_rdy_q;

  always @(negedge clk) begin
    if (cmd_valid && cmd_ready && cmd_n < 16) begin
      cmd_log[cmd_n] = {cmd_cs_release, cmd_dev, cmd_lsb, cmd_ddr, cmd_lanes, cmd_rx, cmd_len};
      cmd_n++;
    end
    if (tx_valid && tx_ready && tx_n < 128) begin
      tx_log[tx_n] = tx_data;
      tx_n++;
    end
    if (evt_bd_done)  bd_n++;
    if (evt_pkt_done) pkt_n++;
    if (evt_err)      err_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    cmd_n = 0; tx_n = 0; bd_n = 0; pkt_n = 0; err_n = 0;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + i;
  endtask

  task automatic put_desc(input int a, input logic [31:0] c, input logic [31:0] b, input logic [31:0] n);
    mem[a/4] = c; mem[a/4+1] = 32'h0; mem[a/4+2] = b; mem[a/4+3] = n;
  endtask

  task automatic write_ctrl(input logic [31:0] base, input logic [2:0] v);
    @(negedge clk);
    base_addr  = base;
    ctrl_wdata = v;
    ctrl_wr    = 1'b1;
    @(negedge clk);
    ctrl_wr    = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, req, 32'(busy), 32'd0);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [16:0] exp_cmd(input logic [31:0] c);
    logic [1:0] ln;
    ln = c[23] ? 2'd2 : (c[22] ? 2'd1 : 2'd0);
    return {c[30], c[29:28], c[25], c[21], ln, c[20], c[8:0]};
  endfunction

  localparam logic [31:0] VEC [0:7] = '{
    32'h8007_0004, 32'hD091_0009, 32'h8260_0100, 32'hB010_0001,
    32'h8001_0000, 32'h8000_0101, 32'h80C0_0008, 32'h8002_0007
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rx_seq = 32'h5C00_0000;
    clear_logs();
    fill_mem();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !mem_req && !cmd_valid && !tx_valid, "R1 idle outputs",
        {28'd0, busy, mem_req, cmd_valid, tx_valid}, 32'd0);
    chk(!evt_bd_done && !evt_pkt_done && !evt_err, "R1 events",
        {29'd0, evt_bd_done, evt_pkt_done, evt_err}, 32'd0);

    // R2 start without enable is ignored
    write_ctrl(32'h40, 3'b100);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req, "R2 start w/o enable", {30'd0, busy, mem_req}, 32'd0);

    // vector table: single descriptor cases
    for (int v = 0; v < 8; v++) begin
      logic [31:0] c;
      int len, wn;
      bit bad;
      c = VEC[v];
      fill_mem();
      clear_logs();
      rx_seq = 32'h5C00_0000 + 32'(v * 256);
      put_desc(32'h40, c, 32'h200, 32'h0);
      len = int'(c[8:0]);
      bad = (len == 0) || (len > 256) || (c[22] && c[23]);
      wn  = (len + 3) / 4;
      write_ctrl(32'h40, 3'b101);
      if (v == 0) chk(mem_req && !mem_we && mem_addr == 32'h40, "R2 first fetch at base", mem_addr, 32'h40);
      wait_idle("R2 walk ends");
      if (bad) begin
        chk(err_n == 1, "R10 error pulse", 32'(err_n), 32'd1);
        chk(cmd_n == 0, "R10 no command", 32'(cmd_n), 32'd0);
        chk(mem[16] == c, "R10 no writeback", mem[16], c);
      end else begin
        chk(err_n == 0, "R10 no error", 32'(err_n), 32'd0);
        chk(cmd_n == 1 && cmd_log[0] == exp_cmd(c), "R3 command fields",
            {15'd0, cmd_log[0]}, {15'd0, exp_cmd(c)});
        if (c[20]) begin
          for (int i = 0; i < wn; i++)
            chk(mem[128+i] == 32'h5C00_0000 + 32'(v * 256 + i), "R5 rx word",
                mem[128+i], 32'h5C00_0000 + 32'(v * 256 + i));
          chk(mem[128+wn] == 32'hA500_0000 + 32'(128 + wn), "R5 no overrun",
              mem[128+wn], 32'hA500_0000 + 32'(128 + wn));
        end else begin
          chk(tx_n == wn, "R4 tx word count", 32'(tx_n), 32'(wn));
          for (int i = 0; i < wn; i++)
            chk(tx_log[i] == 32'hA500_0000 + 32'(128 + i), "R4 tx word",
                tx_log[i], 32'hA500_0000 + 32'(128 + i));
        end
        chk(mem[16] == (c & 32'h7FFF_FFFF), "R6 writeback", mem[16], c & 32'h7FFF_FFFF);
        chk(bd_n == int'(c[16]), "R7 descriptor event", 32'(bd_n), 32'(c[16]));
        chk(pkt_n == int'(c[17] & c[18]), "R7 packet event", 32'(pkt_n), 32'(c[17] & c[18]));
      end
    end

    // R8 chain ends on end-of-list bit though next is non-zero
    fill_mem(); clear_logs();
    put_desc(32'h40, 32'h8001_0008, 32'h200, 32'h80);
    put_desc(32'h80, 32'h8016_0004, 32'h300, 32'hC0);
    put_desc(32'hC0, 32'h8008_0004, 32'h280, 32'h40);
    write_ctrl(32'h40, 3'b101);
    wait_idle("R8 chain idle");
    chk(cmd_n == 3, "R8 three commands", 32'(cmd_n), 32'd3);
    chk(cmd_log[1] == exp_cmd(32'h8016_0004), "R8 second command order",
        {15'd0, cmd_log[1]}, {15'd0, exp_cmd(32'h8016_0004)});
    chk(tx_n == 3 && tx_log[2] == 32'hA500_00A0, "R8 third descriptor buffer", tx_log[2], 32'hA500_00A0);
    chk(mem[16][31] == 1'b0 && mem[32][31] == 1'b0 && mem[48][31] == 1'b0, "R6 all released",
        {mem[16][31], mem[32][31], mem[48][31]}, 32'd0);
    chk(bd_n == 1 && pkt_n == 1, "R7 chain events", {bd_n[15:0], pkt_n[15:0]}, {16'd1, 16'd1});

    // R8 null next pointer ends the chain (descriptor at 0 would add a command)
    fill_mem(); clear_logs();
    put_desc(32'h0, 32'h8000_0004, 32'h200, 32'h0);
    put_desc(32'h40, 32'h8000_0004, 32'h200, 32'h80);
    put_desc(32'h80, 32'h8000_0004, 32'h200, 32'h0);
    write_ctrl(32'h40, 3'b101);
    wait_idle("R8 null idle");
    chk(cmd_n == 2, "R8 null next stops", 32'(cmd_n), 32'd2);

    // R9 not owned without poll
    fill_mem(); clear_logs();
    put_desc(32'h40, 32'h0001_0004, 32'h200, 32'h0);
    write_ctrl(32'h40, 3'b101);
    wait_idle("R9 unowned idle");
    chk(cmd_n == 0 && err_n == 0 && bd_n == 0, "R9 unowned no action",
        32'(cmd_n + err_n + bd_n), 32'd0);
    chk(mem[16] == 32'h0001_0004, "R9 unowned untouched", mem[16], 32'h0001_0004);

    // R9 poll until owned
    clear_logs();
    write_ctrl(32'h40, 3'b111);
    repeat (30) @(negedge clk);
    chk(busy && cmd_n == 0, "R9 polling", {31'd0, busy}, 32'd1);
    mem[16] = 32'h8001_0004;
    wait_idle("R9 poll idle");
    chk(cmd_n == 1 && bd_n == 1, "R9 poll completes", 32'(cmd_n), 32'd1);

    // R11 abort mid transfer
    fill_mem(); clear_logs();
    put_desc(32'h40, 32'h8000_0100, 32'h200, 32'h0);
    tx_rdy_q = 1'b0;
    write_ctrl(32'h40, 3'b101);
    repeat (20) @(negedge clk);
    chk(busy && tx_valid, "R11 stalled before abort", {30'd0, busy, tx_valid}, 32'd3);
    write_ctrl(32'h0, 3'b000);
    chk(!busy && !mem_req && !cmd_valid && !tx_valid, "R11 abort idles",
        {28'd0, busy, mem_req, cmd_valid, tx_valid}, 32'd0);
    tx_rdy_q = 1'b1;
    repeat (5) @(negedge clk);
    chk(mem[16] == 32'h8000_0100 && tx_n == 0, "R11 no writeback", mem[16], 32'h8000_0100);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule